// File: doc/BRIEF.md
# Predicated Commit Gate

This block sits at the writeback end of a single-issue execution pipeline. It decides, for one issued operation per cycle, whether that operation's results become architectural state. Each operation carries a 4-bit condition code. The block tests that code against a stored set of four status flags: negative, zero, carry and overflow. The test yields a pass/fail predicate, and the predicate gates two things. The first is the destination register write-enable. The second is the update of the flag register itself. An operation whose condition fails leaves the registers and the flags exactly as they were.

An operation with its set-flags bit raised, or one marked as compare-class, loads the ALU's result flags into the flag register when its condition passes. The flags are registered, so the operation issued in the next cycle is evaluated against the new values. This is how a compare followed by a conditional add works.

The issue side is a valid strobe with no ready. The block accepts one operation in every cycle and never applies back-pressure. Upstream may therefore present back-to-back valid operations without stalling. In a cycle with the strobe low, no state changes and no write is enabled.

Top module: `predicate_commit_gate`

## Requirements
- R1: A synchronous active-high reset clears all four flags to 4'b0000 on the next rising edge. Flag bit order is {N, Z, C, V} = flags[3:0].
- R2: Condition codes 0000 to 1101 pass as follows. 0000 Z; 0001 !Z; 0010 C; 0011 !C; 0100 N; 0101 !N; 0110 V; 0111 !V; 1000 C&!Z; 1001 !C|Z; 1010 N==V; 1011 N!=V; 1100 !Z&(N==V); 1101 Z|(N!=V).
- R3: Code 1110 passes for every flag value.
- R4: Code 1111 never passes, so it commits nothing.
- R5: The register write-enable is high exactly when the strobe, the write request and the condition pass are all high. A failed condition never enables a write.
- R6: When a valid operation passes with the set-flags bit high, the flag register loads the ALU flags at the rising edge. The new value is visible on the flag output and to the predicate in the next cycle.
- R7: A valid, passing compare-class operation loads the ALU flags even when its set-flags bit is clear.
- R8: The flags hold their value when the strobe is low, when the condition fails, or when neither the set-flags bit nor the compare-class input is high.
- R9: Code 1100 (signed greater-than) passes only when Z is 0 and N equals V.
- R10: No back-pressure. An operation issued in the cycle right after a flag-setting operation is evaluated against the flags that operation produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is issued this cycle |
| op_cond | input | 4 | Condition code of the operation |
| op_setflags | input | 1 | Operation asks to write the flags |
| op_is_cmp | input | 1 | Operation is compare-class (writes flags whenever it passes) |
| op_wr_req | input | 1 | Operation has a destination register to write |
| alu_flags | input | 4 | Result flags {N,Z,C,V} from the ALU |
| rf_wr_en | output | 1 | Gated destination register write-enable |
| cond_pass | output | 1 | Predicate of op_cond against the stored flags |
| flags_q | output | 4 | Current stored flags {N,Z,C,V} |

## Verification
Several behaviours are checked by assertions on every cycle. These are: the always and never codes, the fact that a failed predicate cannot raise the write-enable, and the flag register either loading the ALU flags or staying stable depending on the update condition. The full predicate table for all codes against every flag value needs the bench's sweep. So do the signed greater-than corner cases, reset clearing and the compare-then-conditional sequence across consecutive cycles.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
  parameter int COND_W = 4;
  parameter int FLAG_W = 4;

  localparam int FN = FLAG_W - 1;
  localparam int FZ = FLAG_W - 2;
  localparam int FC = FLAG_W - 3;
  localparam int FV = FLAG_W - 4;

  typedef enum logic [COND_W-1:0] {
    CC_ZSET  = 4'h0, CC_ZCLR  = 4'h1,
    CC_CSET  = 4'h2, CC_CCLR  = 4'h3,
    CC_NSET  = 4'h4, CC_NCLR  = 4'h5,
    CC_VSET  = 4'h6, CC_VCLR  = 4'h7,
    CC_UHI   = 4'h8, CC_ULS   = 4'h9,
    CC_SGE   = 4'hA, CC_SLT   = 4'hB,
    CC_SGT   = 4'hC, CC_SLE   = 4'hD,
    CC_ALW   = 4'hE, CC_NEVER = 4'hF
  } cond_e;
endpackage

// File: rtl/pcg_cond_eval.sv
module pcg_cond_eval
  import pcg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [COND_W-1:0] cond,
  input  logic [FLAG_W-1:0] flags,
  output logic              pass
);
  logic n, z, c, v;
  assign n = flags[FN];
  assign z = flags[FZ];
  assign c = flags[FC];
  assign v = flags[FV];

  always_comb begin
    unique case (cond_e'(cond))
      CC_ZSET:  pass = z;
      CC_ZCLR:  pass = !z;
      CC_CSET:  pass = c;
      CC_CCLR:  pass = !c;
      CC_NSET:  pass = n;
      CC_NCLR:  pass = !n;
      CC_VSET:  pass = v;
      CC_VCLR:  pass = !v;
      CC_UHI:   pass = c && !z;
      CC_ULS:   pass = !c || z;
      CC_SGE:   pass = (n == v);
      CC_SLT:   pass = (n != v);
      CC_SGT:   pass = !z && (n == v);
      CC_SLE:   pass = z || (n != v);
      CC_ALW:   pass = 1'b1;
      default:  pass = 1'b0;
    endcase
  end

  AST_ALWAYS_PASSES: assert property (@(posedge clk) disable iff (rst)
    (cond == CC_ALW) |-> pass); // R3
  AST_NEVER_PASSES: assert property (@(posedge clk) disable iff (rst)
    (cond == CC_NEVER) |-> !pass); // R4
  AST_SGT_NEEDS_NZ: assert property (@(posedge clk) disable iff (rst)
    (cond == CC_SGT && pass) |-> (!flags[FZ] && flags[FN] == flags[FV])); // R9
endmodule

// File: rtl/pcg_flag_reg.sv
module pcg_flag_reg
  import pcg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [FLAG_W-1:0] nxt,
  output logic [FLAG_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= nxt;
  end

  AST_FLAGS_LOAD: assert property (@(posedge clk) disable iff (rst)
    load |=> (q == $past(nxt))); // R6
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q)); // R8
endmodule

// File: rtl/pcg_commit_ctl.sv
module pcg_commit_ctl (
  input  logic clk,
  input  logic rst,
  input  logic valid,
  input  logic pass,
  input  logic wr_req,
  input  logic setflags,
  input  logic is_cmp,
  output logic rf_we,
  output logic flag_we
);
  logic commit;
  assign commit  = valid & pass;
  assign rf_we   = commit & wr_req;
  assign flag_we = commit & (setflags | is_cmp);

  AST_FAIL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !pass |-> !rf_we && !flag_we); // R5
  AST_IDLE_NO_FLAGS: assert property (@(posedge clk) disable iff (rst)
    !valid |-> !flag_we); // R8
endmodule

// File: rtl/predicate_commit_gate.sv
module predicate_commit_gate
  import pcg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [COND_W-1:0] op_cond,
  input  logic              op_setflags,
  input  logic              op_is_cmp,
  input  logic              op_wr_req,
  input  logic [FLAG_W-1:0] alu_flags,
  output logic              rf_wr_en,
  output logic              cond_pass,
  output logic [FLAG_W-1:0] flags_q
);
  logic flag_we;

  pcg_cond_eval u_eval (
    .clk(clk), .rst(rst), .cond(op_cond), .flags(flags_q), .pass(cond_pass)
  );

  pcg_commit_ctl u_ctl (
    .clk(clk), .rst(rst), .valid(op_valid), .pass(cond_pass),
    .wr_req(op_wr_req), .setflags(op_setflags), .is_cmp(op_is_cmp),
    .rf_we(rf_wr_en), .flag_we(flag_we)
  );

  pcg_flag_reg u_flags (
    .clk(clk), .rst(rst), .load(flag_we), .nxt(alu_flags), .q(flags_q)
  );

  AST_CMP_WRITES_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (op_valid && cond_pass && op_is_cmp) |=> (flags_q == $past(alu_flags))); // R7
endmodule

// File: tb/predicate_commit_gate_bench.sv
module predicate_commit_gate_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic [3:0] op_cond = 4'hE;
  logic       op_setflags = 1'b0;
  logic       op_is_cmp = 1'b0;
  logic       op_wr_req = 1'b0;
  logic [3:0] alu_flags = 4'h0;
  logic       rf_wr_en;
  logic       cond_pass;
  logic [3:0] flags_q;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  predicate_commit_gate u_predicate_commit_gate (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_cond(op_cond),
    .op_setflags(op_setflags), .op_is_cmp(op_is_cmp), .op_wr_req(op_wr_req),
    .alu_flags(alu_flags), .rf_wr_en(rf_wr_en), .cond_pass(cond_pass),
    .flags_q(flags_q)
  );

  // Reference predicate, flags = {N,Z,C,V}
  function automatic logic ref_pass(input logic [3:0] cc, input logic [3:0] f);
    logic n, z, c, v;
    {n, z, c, v} = f;
    case (cc)
      4'h0: return z;          4'h1: return !z;
      4'h2: return c;          4'h3: return !c;
      4'h4: return n;          4'h5: return !n;
      4'h6: return v;          4'h7: return !v;
      4'h8: return c & !z;     4'h9: return !c | z;
      4'hA: return n == v;     4'hB: return n != v;
      4'hC: return !z & (n == v);
      4'hD: return z | (n != v);
      4'hE: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [3:0] cc, input logic s,
                       input logic cmp, input logic wr, input logic [3:0] f);
    op_valid = v; op_cond = cc; op_setflags = s;
    op_is_cmp = cmp; op_wr_req = wr; alu_flags = f;
  endtask

  // Load flags via an always-code set-flags op; returns at a negedge.
  task automatic load_flags(input logic [3:0] f);
    @(negedge clk);
    drive(1'b1, 4'hE, 1'b1, 1'b0, 1'b0, f);
    @(negedge clk);
    drive(1'b0, 4'hE, 1'b0, 1'b0, 1'b0, 4'h0);
  endtask

  task automatic t_reset;
    load_flags(4'hB);
    check("R6 preload", flags_q, 4'hB);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset clears flags", flags_q, 4'h0);
    rst = 1'b0;
  endtask

  task automatic t_sweep;
    for (int f = 0; f < 16; f++) begin
      load_flags(4'(f));
      for (int cc = 0; cc < 16; cc++) begin
        op_cond = 4'(cc);
        #1;
        if (cc == 14)      check("R3 always", cond_pass, 1);
        else if (cc == 15) check("R4 never", cond_pass, 0);
        else if (cc == 12) check("R9 signed gt", cond_pass, ref_pass(4'hC, 4'(f)));
        else               check("R2 decode", cond_pass, ref_pass(4'(cc), 4'(f)));
      end
    end
  endtask

  task automatic t_wr_gate;
    load_flags(4'h4); // Z=1
    for (int k = 0; k < 8; k++) begin
      logic v, wr, useeq;
      {v, wr, useeq} = 3'(k);
      drive(v, useeq ? 4'h0 : 4'h1, 1'b0, 1'b0, wr, 4'h0);
      #1;
      check("R5 write gate", rf_wr_en, v & wr & useeq);
    end
    drive(1'b1, 4'hF, 1'b0, 1'b0, 1'b1, 4'h0);
    #1;
    check("R4 never writes", rf_wr_en, 0);
    drive(1'b0, 4'hE, 1'b0, 1'b0, 1'b0, 4'h0);
  endtask

  task automatic t_sbit;
    load_flags(4'h2);
    // S clear, not compare: flags hold
    drive(1'b1, 4'hE, 1'b0, 1'b0, 1'b1, 4'hD);
    @(negedge clk);
    check("R8 S clear holds", flags_q, 4'h2);
    // S set but condition fails (Z clear, code 0000)
    drive(1'b1, 4'h0, 1'b1, 1'b0, 1'b0, 4'hD);
    @(negedge clk);
    check("R8 failed cond holds", flags_q, 4'h2);
    // S set, not valid
    drive(1'b0, 4'hE, 1'b1, 1'b1, 1'b0, 4'hD);
    @(negedge clk);
    check("R8 idle holds", flags_q, 4'h2);
    // S set, passing (C=1, code 0010)
    drive(1'b1, 4'h2, 1'b1, 1'b0, 1'b0, 4'h9);
    @(negedge clk);
    check("R6 S set loads", flags_q, 4'h9);
    drive(1'b0, 4'hE, 1'b0, 1'b0, 1'b0, 4'h0);
  endtask

  task automatic t_cmp;
    load_flags(4'h0);
    drive(1'b1, 4'hE, 1'b0, 1'b1, 1'b0, 4'h6);
    @(negedge clk);
    check("R7 compare loads", flags_q, 4'h6);
    // compare whose condition fails (Z=1 now, code 0001) holds
    drive(1'b1, 4'h1, 1'b0, 1'b1, 1'b0, 4'hF);
    @(negedge clk);
    check("R7 failed compare holds", flags_q, 4'h6);
    drive(1'b0, 4'hE, 1'b0, 1'b0, 1'b0, 4'h0);
  endtask

  task automatic t_back_to_back;
    load_flags(4'h4); // Z=1: gt fails
    // compare yields "greater" flags (all clear)
    drive(1'b1, 4'hE, 1'b0, 1'b1, 1'b0, 4'h0);
    @(negedge clk);
    // conditional add with S, produces Z=1
    drive(1'b1, 4'hC, 1'b1, 1'b0, 1'b1, 4'h4);
    #1;
    check("R10 gt sees compare", cond_pass, 1);
    check("R10 gt writes", rf_wr_en, 1);
    @(negedge clk);
    drive(1'b1, 4'hC, 1'b0, 1'b0, 1'b1, 4'h0);
    #1;
    check("R10 next sees new Z", cond_pass, 0);
    check("R10 no write", rf_wr_en, 0);
    // signed less: N!=V means gt fails even with Z clear
    drive(1'b1, 4'hE, 1'b0, 1'b1, 1'b0, 4'h8);
    @(negedge clk);
    drive(1'b1, 4'hC, 1'b0, 1'b0, 1'b1, 4'h0);
    #1;
    check("R9 N!=V fails gt", cond_pass, 0);
    drive(1'b0, 4'hE, 1'b0, 1'b0, 1'b0, 4'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 flags after reset", flags_q, 4'h0);
    t_reset();
    t_sweep();
    t_wr_gate();
    t_sbit();
    t_cmp();
    t_back_to_back();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule